// File: doc/BRIEF.md
# Dual-bank bus address relocator

This block widens an 18-bit bus address (256 KB) into a 22-bit physical memory address (4 MB). It keeps two separate banks of 32 page registers. One bank maps cycles started by the processor and the other maps cycles started by DMA devices. A cycle-type input picks the bank for each request. Bus address bits 17:13 pick the register inside the bank, and that register supplies the physical base of the 8 KB page. The processor register is chosen from the bus address alone. No processor mode, privilege level or instruction/data information is used. There is no length or permission checking, only base relocation.

Processor entries hold a 16-bit base in 64-byte units. DMA entries hold a 22-bit byte base whose bit 0 is always stored as zero. The top 8 KB of bus space is the I/O page, and it goes past both banks to a fixed physical window. Software loads the banks through a one-cycle write port. Translation is registered, so a result appears one clock after its request.

Top module: `bus_relocator`

## Requirements
- R1: While rst_ni is low, out_valid_o, out_dma_o and out_addr_o are 0. After reset, entry n of both banks maps bus page n to physical page n, so every non-I/O bus address comes out unchanged, zero-extended to 22 bits.
- R2: Processor translation (in_dma_i = 0) outputs (base × 64 + in_addr_i[12:0]) modulo 2^22, where base is bits 15:0 of the data last written to that processor entry.
- R3: The processor entry is selected only by in_addr_i[17:13]. A write to one processor entry changes the translation of that page only.
- R4: DMA translation (in_dma_i = 1) outputs (base + in_addr_i[12:0]) modulo 2^22. Here base is the 22-bit data last written to that DMA entry, with bit 0 cleared.
- R5: The two banks are independent. A write with wr_dma_i = 0 never changes a DMA translation, and a write with wr_dma_i = 1 never changes a processor translation.
- R6: When in_addr_i[17:13] = 5'b11111, the output is 22'h3FE000 | in_addr_i[12:0] for either bank, whatever entry 31 holds.
- R7: out_valid_o equals in_valid_i delayed by one clock. out_addr_o and out_dma_o carry the translation and the in_dma_i value of the request from the previous clock.
- R8: A write accepted on one clock edge is not seen by a translation sampled on that same edge. It is seen by translations sampled on every later edge.
- R9: When in_valid_i is low, out_addr_o and out_dma_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Page register write strobe |
| wr_dma_i | input | 1 | Write bank select: 0 processor, 1 DMA |
| wr_idx_i | input | 5 | Page register index |
| wr_data_i | input | 22 | Write data; the processor bank uses bits 15:0 |
| in_valid_i | input | 1 | Translation request valid |
| in_dma_i | input | 1 | Request bank: 0 processor, 1 DMA |
| in_addr_i | input | 18 | Bus address |
| out_valid_o | output | 1 | Translation result valid |
| out_dma_o | output | 1 | Bank used for the result |
| out_addr_o | output | 22 | Physical address |

## Verification
The bench drives a processor base of 0xFFFF and a DMA base near the top of the range, so the sum runs past 4 MB. A design that widened the sum or saturated it would give a wrong address instead of a wrapped one. It writes an odd DMA base and checks that the result keeps the offset parity. A design that stored bit 0 would be off by one. It loads entry 31 of both banks with unrelated values and checks that the I/O page output ignores them. It writes one bank and reads the other, to catch banks that are merged or swapped. It issues a write and a translation on the same edge, to catch a write that bypasses into the same-cycle result. It also drops in_valid_i while moving the address, to catch outputs that are not held.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int BUS_AW     = 18;
  localparam int PHYS_AW    = 22;
  localparam int PAGE_OFS_W = 13;
  localparam int CPU_BASE_W = 16;
  localparam int CPU_UNIT_SH = 6;  // processor base counts 64-byte units
  localparam int DMA_BASE_W = PHYS_AW;
endpackage

// File: rtl/reloc_bank.sv
module reloc_bank #(
  parameter int IW     = 5,
  parameter int W      = 16,
  parameter int ID_SH  = 7,   // reset value of entry n is n << ID_SH
  parameter bit EVEN   = 1'b0,
  localparam int N     = 1 << IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  localparam logic [W-1:0] WMASK = EVEN ? ~W'(1) : '1;

  logic [W-1:0] ent_q [N];
  logic [W-1:0] wval;

  assign wval = wdata_i & WMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ent_q[i] <= W'(i << ID_SH);
    end else if (we_i) begin
      ent_q[widx_i] <= wval;
    end
  end

  assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/reloc_calc.sv
module reloc_calc #(
  parameter int BUS_AW  = 18,
  parameter int PHYS_AW = 22,
  parameter int OFS_W   = 13,
  parameter int CPU_W   = 16,
  parameter int CPU_SH  = 6,
  parameter int DMA_W   = 22
) (
  input  logic               dma_i,
  input  logic [BUS_AW-1:0]  addr_i,
  input  logic [CPU_W-1:0]   cpu_base_i,
  input  logic [DMA_W-1:0]   dma_base_i,
  output logic [PHYS_AW-1:0] paddr_o
);
  logic               io_page;
  logic [PHYS_AW-1:0] ofs, cpu_sum, dma_sum, io_addr;

  assign io_page = &addr_i[BUS_AW-1:OFS_W];
  assign ofs     = PHYS_AW'(addr_i[OFS_W-1:0]);
  assign cpu_sum = (PHYS_AW'(cpu_base_i) << CPU_SH) + ofs;
  assign dma_sum = PHYS_AW'(dma_base_i) + ofs;
  assign io_addr = {{(PHYS_AW-OFS_W){1'b1}}, addr_i[OFS_W-1:0]};

  always_comb begin
    if (io_page)    paddr_o = io_addr;
    else if (dma_i) paddr_o = dma_sum;
    else            paddr_o = cpu_sum;
  end
endmodule

// File: rtl/bus_relocator.sv
module bus_relocator
  import reloc_pkg::*;
#(
  parameter int BUS_W  = BUS_AW,
  parameter int PHYS_W = PHYS_AW,
  parameter int OFS_W  = PAGE_OFS_W,
  parameter int CPU_W  = CPU_BASE_W,
  parameter int CPU_SH = CPU_UNIT_SH,
  localparam int IW    = BUS_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_dma_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [PHYS_W-1:0] wr_data_i,
  input  logic              in_valid_i,
  input  logic              in_dma_i,
  input  logic [BUS_W-1:0]  in_addr_i,
  output logic              out_valid_o,
  output logic              out_dma_o,
  output logic [PHYS_W-1:0] out_addr_o
);
  logic [IW-1:0]     page_idx;
  logic [CPU_W-1:0]  cpu_base;
  logic [PHYS_W-1:0] dma_base;
  logic [PHYS_W-1:0] paddr;

  assign page_idx = in_addr_i[BUS_W-1:OFS_W];

  reloc_bank #(.IW(IW), .W(CPU_W), .ID_SH(OFS_W - CPU_SH), .EVEN(1'b0)) u_cpu_bank (
    .clk_i, .rst_ni,
    .we_i   (wr_en_i && !wr_dma_i),
    .widx_i (wr_idx_i),
    .wdata_i(wr_data_i[CPU_W-1:0]),
    .ridx_i (page_idx),
    .rdata_o(cpu_base)
  );

  reloc_bank #(.IW(IW), .W(PHYS_W), .ID_SH(OFS_W), .EVEN(1'b1)) u_dma_bank (
    .clk_i, .rst_ni,
    .we_i   (wr_en_i && wr_dma_i),
    .widx_i (wr_idx_i),
    .wdata_i(wr_data_i),
    .ridx_i (page_idx),
    .rdata_o(dma_base)
  );

  reloc_calc #(
    .BUS_AW(BUS_W), .PHYS_AW(PHYS_W), .OFS_W(OFS_W),
    .CPU_W(CPU_W), .CPU_SH(CPU_SH), .DMA_W(PHYS_W)
  ) u_calc (
    .dma_i     (in_dma_i),
    .addr_i    (in_addr_i),
    .cpu_base_i(cpu_base),
    .dma_base_i(dma_base),
    .paddr_o   (paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_dma_o   <= 1'b0;
      out_addr_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_dma_o  <= in_dma_i;
        out_addr_o <= paddr;
      end
    end
  end
endmodule

// File: rtl/bus_relocator_chk.sv
module bus_relocator_chk #(
  parameter int BUS_W  = 18,
  parameter int PHYS_W = 22,
  parameter int OFS_W  = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_dma_i,
  input logic [BUS_W-1:0]  in_addr_i,
  input logic              out_valid_o,
  input logic              out_dma_o,
  input logic [PHYS_W-1:0] out_addr_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);  // R7
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);  // R7
  AST_BANK_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_dma_o == $past(in_dma_i));  // R7
  AST_IO_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && &in_addr_i[BUS_W-1:OFS_W]) |=>
      out_addr_o == {{(PHYS_W-OFS_W){1'b1}}, $past(in_addr_i[OFS_W-1:0])});  // R6
  AST_DMA_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_dma_i) |=> out_addr_o[0] == $past(in_addr_i[0]));  // R4
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(out_addr_o) && $stable(out_dma_o)));  // R9
endmodule

bind bus_relocator bus_relocator_chk #(.BUS_W(BUS_W), .PHYS_W(PHYS_W), .OFS_W(OFS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_dma_i   (in_dma_i),
  .in_addr_i  (in_addr_i),
  .out_valid_o(out_valid_o),
  .out_dma_o  (out_dma_o),
  .out_addr_o (out_addr_o)
);

// File: tb/bus_relocator_bench.sv
`timescale 1ns/1ps
module bus_relocator_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_dma_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [21:0] wr_data_i = '0;
  logic        in_valid_i = 1'b0, in_dma_i = 1'b0;
  logic [17:0] in_addr_i = '0;
  logic        out_valid_o, out_dma_o;
  logic [21:0] out_addr_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] cpu_m [32];
  logic [21:0] dma_m [32];

  always #4 clk_i = ~clk_i;  // 125 MHz

  bus_relocator u_bus_relocator (.*);

  function automatic logic [21:0] model(input logic dma, input logic [17:0] a);
    logic [21:0] ofs = {9'd0, a[12:0]};
    if (a[17:13] == 5'd31) return 22'h3FE000 | ofs;
    if (dma) return (dma_m[a[17:13]] & ~22'd1) + ofs;
    return ({6'd0, cpu_m[a[17:13]]} << 6) + ofs;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic dma, input logic [4:0] idx, input logic [21:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_dma_i = dma; wr_idx_i = idx; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    if (dma) dma_m[idx] = d; else cpu_m[idx] = d[15:0];
  endtask

  // Issue one request, check result after the capturing edge.
  task automatic xlate(input string req, input logic dma, input logic [17:0] a);
    logic [21:0] exp = model(dma, a);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_dma_i = dma; in_addr_i = a;
    @(posedge clk_i); #2;
    in_valid_i = 1'b0;
    check(req, {31'd0, out_valid_o}, 32'd1);
    check(req, {31'd0, out_dma_o}, {31'd0, dma});
    check(req, {10'd0, out_addr_o}, {10'd0, exp});
  endtask

  task automatic t_reset;
    check("R1", {31'd0, out_valid_o}, 0);
    check("R1", {31'd0, out_dma_o}, 0);
    check("R1", {10'd0, out_addr_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    xlate("R1", 1'b0, 18'h0A123);
    check("R1", {10'd0, out_addr_o}, 32'h0A123);
    xlate("R1", 1'b1, 18'h12345);
    check("R1", {10'd0, out_addr_o}, 32'h12345);
  endtask

  task automatic t_same_edge;  // R8
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_dma_i = 1'b1; wr_idx_i = 5'd3; wr_data_i = 22'h2C0000;
    in_valid_i = 1'b1; in_dma_i = 1'b1; in_addr_i = 18'h06010;
    @(posedge clk_i); #2;
    wr_en_i = 1'b0; in_valid_i = 1'b0;
    check("R8 old", {10'd0, out_addr_o}, 32'h06010);
    dma_m[3] = 22'h2C0000;
    xlate("R8 new", 1'b1, 18'h06010);
    check("R8 new", {10'd0, out_addr_o}, 32'h2C0010);
  endtask

  task automatic t_cpu;
    wr(1'b0, 5'd5, 22'h3FABCD);  // upper bits ignored
    xlate("R2", 1'b0, 18'h0A123);
    check("R2", {10'd0, out_addr_o}, 32'h2AF463);
    xlate("R3", 1'b0, 18'h08044);
    xlate("R3", 1'b0, 18'h0C055);
    wr(1'b0, 5'd2, 22'h00FFFF);
    xlate("R2 wrap", 1'b0, 18'h05FFF);
    check("R2 wrap", {10'd0, out_addr_o}, 32'h001FBF);
  endtask

  task automatic t_dma;
    wr(1'b1, 5'd7, 22'h3A0001);
    xlate("R4 even", 1'b1, 18'h0E001);
    check("R4 even", {10'd0, out_addr_o}, 32'h3A0001);
    wr(1'b1, 5'd9, 22'h3FFFFE);
    xlate("R4 wrap", 1'b1, 18'h13FFF);
    check("R4 wrap", {10'd0, out_addr_o}, 32'h001FFD);
  endtask

  task automatic t_banks;  // R5
    xlate("R5", 1'b1, 18'h0A100);  // DMA page 5 untouched by processor write
    check("R5", {10'd0, out_addr_o}, 32'h0A100);
    xlate("R5", 1'b0, 18'h0E200);  // processor page 7 untouched by DMA write
    check("R5", {10'd0, out_addr_o}, 32'h0E200);
  endtask

  task automatic t_io;  // R6
    wr(1'b0, 5'd31, 22'h001234);
    wr(1'b1, 5'd31, 22'h100000);
    xlate("R6", 1'b0, 18'h3E456);
    check("R6", {10'd0, out_addr_o}, 32'h3FE456);
    xlate("R6", 1'b1, 18'h3FFFF);
    check("R6", {10'd0, out_addr_o}, 32'h3FFFFF);
  endtask

  task automatic t_hold;  // R7, R9
    logic [21:0] prev;
    xlate("R7", 1'b1, 18'h0E004);
    prev = out_addr_o;
    @(negedge clk_i); in_addr_i = 18'h00000; in_dma_i = 1'b0;
    @(posedge clk_i); #2;
    check("R7 idle", {31'd0, out_valid_o}, 0);
    check("R9", {10'd0, out_addr_o}, {10'd0, prev});
    check("R9", {31'd0, out_dma_o}, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      cpu_m[i] = 16'(i << 7);
      dma_m[i] = 22'(i << 13);
    end
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    t_same_edge();
    t_cpu();
    t_dma();
    t_banks();
    t_io();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule